// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a serial slave receiver for a two-wire bus (I2C) that accepts only write transfers. Both bus lines are resynchronised into the system clock domain, and bus events are recognised on the synchronised copies. A transfer begins with a START. It then carries the fixed device address byte 88H, a subaddress byte, and one or more data bytes, and it ends with a STOP. The slave pulls the data line low in the ninth clock of every byte it accepts.

Each accepted data byte comes out as a one-cycle write strobe, together with a 4-bit subaddress and the byte itself, and is meant to drive a sixteen-entry register bank. When the buffer-enable input is low, the subaddress advances after every data byte and wraps from 0FH to 00H. When it is high, only one data byte is taken per transfer. Six subaddresses are reserved. They are acknowledged but never strobed.

Top module: `i2c_wr_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) makes the slave busy and starts address matching. A rising data line while the clock line is high (STOP) returns it to idle. While idle, `sda_oe` stays 0.
- R2: An address byte equal to 88H is acknowledged. Any other address byte, including 89H (read), is not acknowledged, and nothing in the transfer is acknowledged or written until the next START.
- R3: For an accepted byte, `sda_oe` is 1 from the clock falling edge after the eighth bit until the falling edge that ends the ninth clock, and it does not change while the clock line is high.
- R4: A subaddress byte of 00H to 0FH is acknowledged and becomes the current subaddress. A subaddress byte of 10H or above is not acknowledged, and the rest of the transfer is ignored.
- R5: Each accepted data byte (received MSB first) produces exactly one one-cycle `wr_stb`, with `wr_addr` equal to the current subaddress and `wr_data` equal to the byte.
- R6: With `buf_en` = 0, every further data byte is acknowledged and written to the previous subaddress plus one, and 0FH is followed by 00H.
- R7: With `buf_en` = 1, only the first data byte after the subaddress is acknowledged and written. Later data bytes get no acknowledge and no strobe.
- R8: Subaddresses 07H, 08H, 09H, 0BH, 0EH and 0FH are acknowledged and take part in auto-increment, but writing them gives no `wr_stb`.
- R9: A START inside a transfer (a repeated START) discards the partial byte and restarts address matching. A valid address, subaddress and data after it are written normally.
- R10: After reset, `sda_oe` and `wr_stb` are 0 and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| buf_en | input | 1 | 1: one data byte per transfer; 0: auto-increment |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_stb | output | 1 | One-cycle write strobe to the register bank |
| wr_addr | output | 4 | Subaddress of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
A wrong bit counter or a wrong transfer state shows at the bus within one byte. The acknowledge appears in the wrong clock, or on a byte that should be refused, and the bench reads every acknowledge bit as the master. A wrong subaddress counter shows at the next strobe, as a write to the wrong register entry. The bench compares its own register image with the one built from strobes after every transfer, so a misplaced, missing or extra write is caught at the end of that transfer.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } xfer_state_t;

  // subaddress byte fits in the sub_w-bit subaddress space
  function automatic logic sub_fits(input logic [7:0] b, input int sub_w);
    return (b >> sub_w) == 8'd0;
  endfunction

  // next subaddress, wrapping at the top of the space
  function automatic logic [3:0] sub_next(input logic [3:0] s);
    return s + 4'd1;
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int CW = 2 * STAGES;

  logic [CW-1:0] chain;
  logic          scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      chain <= {chain[CW-3:0], scl_i, sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = chain[CW-1];
  assign sda_s     = chain[CW-2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_end,
  output logic              in_ack
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bit_cnt;

  assign byte_done = active & scl_fall & (bit_cnt == FULL) & ~in_ack;
  assign ack_end   = active & scl_fall & in_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      rx_byte <= '0;
    end else if (restart || !active) begin
      bit_cnt <= '0;
      in_ack  <= 1'b0;
    end else if (scl_rise && bit_cnt < FULL) begin
      rx_byte <= {rx_byte[DATA_W-2:0], sda_s};
      bit_cnt <= bit_cnt + 1'b1;
    end else if (byte_done) begin
      in_ack <= 1'b1;
    end else if (ack_end) begin
      in_ack  <= 1'b0;
      bit_cnt <= '0;
    end
  end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import i2cw_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              SUB_W       = 4,
  parameter logic [6:0]      DEV_ADDR    = 7'b1000100,
  parameter logic [15:0]     RSVD_MASK   = 16'hCB80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             buf_en,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [SUB_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  // named internal events, used by the bound checker
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_done, ack_end, in_ack, bus_busy;
  logic [7:0] rx_byte;

  xfer_state_t      state, nxt;
  logic             acc, took_one, write_go;
  logic [SUB_W-1:0] sub_q;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign bus_busy = (state != ST_IDLE);

  i2cw_rx #(.DATA_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(start_evt), .active(bus_busy),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .rx_byte(rx_byte), .byte_done(byte_done), .ack_end(ack_end), .in_ack(in_ack)
  );

  always_comb begin
    acc = 1'b0;
    nxt = state;
    unique case (state)
      ST_ADDR: begin
        acc = (rx_byte == ADDR_BYTE);
        nxt = acc ? ST_SUB : ST_SKIP;
      end
      ST_SUB: begin
        acc = sub_fits(rx_byte, SUB_W);
        nxt = acc ? ST_DATA : ST_SKIP;
      end
      ST_DATA: begin
        acc = !buf_en || !took_one;
        nxt = acc ? ST_DATA : ST_SKIP;
      end
      default: begin
        acc = 1'b0;
        nxt = state;
      end
    endcase
  end

  assign write_go = byte_done && (state == ST_DATA) && acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sub_q    <= '0;
      took_one <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state    <= ST_ADDR;
        sda_oe   <= 1'b0;
        took_one <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (byte_done) begin
        sda_oe <= acc;
        state  <= nxt;
        if (state == ST_SUB && acc) begin
          sub_q    <= rx_byte[SUB_W-1:0];
          took_one <= 1'b0;
        end
        if (write_go) begin
          took_one <= 1'b1;
          sub_q    <= sub_next(sub_q);
          wr_addr  <= sub_q;
          wr_data  <= rx_byte;
          wr_stb   <= ~RSVD_MASK[sub_q];
        end
      end else if (ack_end) begin
        sda_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk #(
  parameter int SUB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic [SUB_W-1:0] wr_addr,
  input logic             bus_busy,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             byte_done,
  input logic             scl_s
);
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> !sda_oe); // R1

  AST_ACK_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe)); // R3

  AST_STB_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done)); // R5

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R5

  AST_NO_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !(wr_addr == 4'h7 || wr_addr == 4'h8 || wr_addr == 4'h9 ||
                 wr_addr == 4'hB || wr_addr == 4'hE || wr_addr == 4'hF)); // R8

  AST_RESTART_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe); // R9

  AST_STB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(bus_busy)); // R2
endmodule

bind i2c_wr_slave i2cw_chk #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .bus_busy(bus_busy), .start_evt(start_evt), .stop_evt(stop_evt),
  .byte_done(byte_done), .scl_s(scl_s)
);

// File: tb/i2c_wr_slave_bench.sv
module i2c_wr_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO_A = 6;   // scl low, before data change
  localparam int LO_B = 6;   // scl low, after data change
  localparam int HI   = 8;   // scl high

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic buf_en = 1'b0;
  logic sda_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_line = m_sda & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [7:0] dut_file [16];
  logic [7:0] ref_file [16];
  int stb_cnt = 0;

  logic [7:0] tx   [20];
  logic       ackv [20];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_wr_slave u_i2c_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .buf_en(buf_en),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      dut_file[wr_addr] <= wr_data;
      stb_cnt <= stb_cnt + 1;
    end
  end

  function automatic bit is_rsvd(input int s);
    return (s >= 7 && s <= 9) || s == 11 || s >= 14;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; waitc(LO_A);
    m_sda = 1'b1; waitc(LO_B);
    m_scl = 1'b1; waitc(HI);
    m_sda = 1'b0; waitc(HI);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; waitc(LO_A);
    m_sda = 1'b0; waitc(LO_B);
    m_scl = 1'b1; waitc(HI);
    m_sda = 1'b1; waitc(HI);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; waitc(LO_A);
      m_sda = b[i]; waitc(LO_B);
      m_scl = 1'b1; waitc(HI);
    end
    m_scl = 1'b0; waitc(LO_A);
    m_sda = 1'b1; waitc(LO_B);
    m_scl = 1'b1; waitc(HI/2);
    ack = ~sda_line;
    waitc(HI/2);
    m_scl = 1'b0;
  endtask

  // run one transfer of n bytes and compare with a model built from the requirements
  task automatic run_xfer(input int n, input string req);
    logic a;
    bit   ok;
    int   cur;
    int   exp_stb;
    int   base;
    logic exp_ack [20];
    base = stb_cnt;
    bus_start();
    for (int i = 0; i < n; i++) begin
      send_byte(tx[i], a);
      ackv[i] = a;
    end
    bus_stop();
    waitc(4);
    ok = (tx[0] == 8'h88);
    exp_ack[0] = ok;
    exp_stb = 0;
    cur = 0;
    if (n > 1) begin
      ok = ok && (tx[1] < 8'h10);
      exp_ack[1] = ok;
      cur = int'(tx[1]) % 16;
    end
    for (int i = 2; i < n; i++) begin
      ok = ok && (!buf_en || i == 2);
      exp_ack[i] = ok;
      if (ok) begin
        if (!is_rsvd(cur)) begin
          ref_file[cur] = tx[i];
          exp_stb++;
        end
        cur = (cur + 1) % 16;
      end
    end
    for (int i = 0; i < n; i++)
      check(ackv[i] == exp_ack[i], $sformatf("%s ack byte %0d", req, i), ackv[i], exp_ack[i]);
    check(stb_cnt - base == exp_stb, {req, " strobe count"}, stb_cnt - base, exp_stb);
    ok = 1;
    for (int s = 0; s < 16; s++) if (dut_file[s] !== ref_file[s]) ok = 0;
    check(ok, {req, " register image"}, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      dut_file[s] = 8'h00;
      ref_file[s] = 8'h00;
    end
    waitc(5);
    // R10: reset state
    check(sda_oe == 1'b0, "R10 sda_oe in reset", sda_oe, 0);
    check(wr_stb == 1'b0, "R10 wr_stb in reset", wr_stb, 0);
    rst_n = 1'b1;
    waitc(10);
    check(sda_oe == 1'b0 && wr_stb == 1'b0, "R10 outputs after reset", {sda_oe, wr_stb}, 0);

    // R4 R5 R8: sweep subaddress bytes 00..1F with one data byte each
    buf_en = 1'b0;
    for (int s = 0; s < 32; s++) begin
      tx[0] = 8'h88; tx[1] = 8'(s); tx[2] = 8'(8'hA5 ^ (s * 37));
      run_xfer(3, "R4/R5/R8 sweep");
    end
    // R4: high subaddress bytes
    tx[0] = 8'h88; tx[1] = 8'h80; tx[2] = 8'h11; run_xfer(3, "R4 sub 80");
    tx[0] = 8'h88; tx[1] = 8'hFF; tx[2] = 8'h22; run_xfer(3, "R4 sub FF");

    // R2: wrong address bytes (read bit, neighbours)
    tx[0] = 8'h89; tx[1] = 8'h01; tx[2] = 8'h33; run_xfer(3, "R2 addr 89");
    tx[0] = 8'h8A; tx[1] = 8'h02; tx[2] = 8'h44; run_xfer(3, "R2 addr 8A");
    tx[0] = 8'h08; tx[1] = 8'h03; tx[2] = 8'h55; run_xfer(3, "R2 addr 08");

    // R6: auto-increment across the wrap, seventeen data bytes from 0D
    tx[0] = 8'h88; tx[1] = 8'h0D;
    for (int i = 2; i < 19; i++) tx[i] = 8'(8'h30 + i * 7);
    run_xfer(19, "R6 autoinc wrap");

    // R7: buffer enable, only the first data byte accepted
    buf_en = 1'b1;
    tx[0] = 8'h88; tx[1] = 8'h02; tx[2] = 8'hC3; tx[3] = 8'h3C; tx[4] = 8'h99;
    run_xfer(5, "R7 single data");
    tx[0] = 8'h88; tx[1] = 8'h0A; tx[2] = 8'h5A; tx[3] = 8'hE1;
    run_xfer(4, "R7 single data 0A");
    buf_en = 1'b0;

    // R9: repeated START mid-byte and after a data byte
    begin
      logic a;
      int base;
      base = stb_cnt;
      bus_start();
      send_byte(8'h88, a);
      check(a == 1'b1, "R9 first addr ack", a, 1);
      for (int i = 7; i >= 4; i--) begin
        m_scl = 1'b0; waitc(LO_A);
        m_sda = 1'(i & 1); waitc(LO_B);
        m_scl = 1'b1; waitc(HI);
      end
      bus_start();
      send_byte(8'h88, a);
      check(a == 1'b1, "R9 addr ack after restart", a, 1);
      send_byte(8'h03, a);
      check(a == 1'b1, "R9 sub ack after restart", a, 1);
      send_byte(8'h6E, a);
      check(a == 1'b1, "R9 data ack after restart", a, 1);
      bus_start();
      send_byte(8'h88, a);
      send_byte(8'h05, a);
      send_byte(8'h7F, a);
      check(a == 1'b1, "R9 data ack second restart", a, 1);
      bus_stop();
      waitc(4);
      ref_file[3] = 8'h6E;
      ref_file[5] = 8'h7F;
      check(stb_cnt - base == 2, "R9 strobe count", stb_cnt - base, 2);
      check(dut_file[3] == 8'h6E, "R9 write sub 3", dut_file[3], 8'h6E);
      check(dut_file[5] == 8'h7F, "R9 write sub 5", dut_file[5], 8'h7F);
    end

    // R1: STOP returns idle; bus clocking without START is ignored
    begin
      logic a;
      int base;
      base = stb_cnt;
      send_byte(8'h88, a);
      check(a == 1'b0, "R1 no ack without START", a, 0);
      send_byte(8'h01, a);
      check(a == 1'b0, "R1 idle ignores bytes", a, 0);
      m_scl = 1'b1; waitc(HI);
      check(stb_cnt == base && sda_oe == 1'b0, "R1 idle no strobe", stb_cnt - base, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule